// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device end of one receive ring held in host memory. Software fills a ring of descriptors, each naming one receive buffer. It hands them to the device by moving a host write index, always in steps of eight. The controller takes words from an incoming frame stream and packs them into the buffer named by the descriptor at its read index. It issues one memory write request per word. When a buffer is full, it closes that buffer and publishes the index of the descriptor it just filled.

A buffer that holds only part of its capacity is closed once no word has arrived for a programmable time. That time is counted in 32-microsecond units, and a parameter gives the clock cycles per unit. Each close can pulse an interrupt. A single configuration word sets the channel mode, the ring size, the buffer size, the interrupt destination and the close timeout. The channel mode is one of off, stop after the current frame, or normal. Once the channel is stopped and has no memory write outstanding, it reports idle.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset the configuration reads 0, the channel is idle, `in_ready`, `irq_o` and `mem_req` are low, and `fill_idx` reads 12'hFFF.
- R2: Register slot 0 holds the configuration: mode in bits 31:30, ring-size exponent in 23:20, buffer size in 17:16, interrupt destination in 13:12 and timeout in 11:4. All other bits read 0. Slot 1 holds the host write index: bits 11:3 are stored and bits 2:0 read 0. Slot 2 reads the idle flag in bit 24 and `fill_idx` in bits 11:0. Read data appears on the cycle after `reg_rd`.
- R3: The ring has 2^n entries, with the exponent n clamped to the range 5 to 12. Both indexes wrap modulo the ring size.
- R4: When the read index equals the host write index, modulo the ring size, no word is accepted.
- R5: A buffer holds (size field + 1) × UNIT_WORDS words. When the write of its last word is acknowledged, the buffer closes. At that point `fill_idx` becomes its descriptor index and the read index advances by one.
- R6: When the destination field is 01, every close produces a one-cycle `irq_o` pulse. When the field is 00, no pulse is produced, but `fill_idx` still updates.
- R7: Mode 00 (and also 11) stops word acceptance on the cycle after it is written. Idle reads 1 once no memory write is pending.
- R8: Mode 01 keeps accepting words until the word marked as the end of a frame is taken, then stops and goes idle. If no frame is open, the channel stops at once.
- R9: Each accepted word produces one memory write at address {descriptor index, word offset}. The request holds its address and data until it is acknowledged, and no new word is taken while a request is pending.
- R10: A partly filled buffer closes once no word has been accepted for timeout × TICKS_PER_UNIT cycles. Every accepted word restarts this count. A timeout of 0 disables the close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| in_valid | input | 1 | Incoming word valid |
| in_data | input | DATA_W | Incoming word |
| in_last | input | 1 | Incoming word ends its frame |
| in_ready | output | 1 | Controller takes the word this cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 12+log2(4·UNIT_WORDS) | Descriptor index and word offset |
| mem_data | output | DATA_W | Word to write |
| mem_ack | input | 1 | Memory write accepted |
| irq_o | output | 1 | One-cycle interrupt pulse on buffer close |
| fill_idx | output | 12 | Index of the most recently filled descriptor |
| idle_o | output | 1 | Channel stopped with nothing outstanding |

## Verification
Two events can fall on the same clock edge: a buffer close that advances the read index, and a host write that moves the write index. The bench provokes this by leaving the ring one descriptor short of full. It then lines up the acknowledge of a buffer's final word with a register write that adds eight more descriptors. The outcome is judged at the ports. `fill_idx` must name the closed descriptor, and the channel must still accept words after the next buffer is filled; that is possible only if the write-index update survived the close. A second same-edge case is also checked: a channel-off write that lands on the acknowledge of a buffer's final word must still close that buffer and then report idle.

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int DATA_W         = 32,
  parameter int UNIT_WORDS     = 1024,
  parameter int TICKS_PER_UNIT = 3200
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_wr,
  input  logic                                reg_rd,
  input  logic [1:0]                          reg_addr,
  input  logic [31:0]                         reg_wdata,
  output logic [31:0]                         reg_rdata,
  input  logic                                in_valid,
  input  logic [DATA_W-1:0]                   in_data,
  input  logic                                in_last,
  output logic                                in_ready,
  output logic                                mem_req,
  output logic [11+$clog2(4*UNIT_WORDS):0]    mem_addr,
  output logic [DATA_W-1:0]                   mem_data,
  input  logic                                mem_ack,
  output logic                                irq_o,
  output logic [11:0]                         fill_idx,
  output logic                                idle_o
);
  localparam int WOFF_W = $clog2(4*UNIT_WORDS);
  localparam int CNT_W  = WOFF_W + 1;
  localparam int ADDR_W = 12 + WOFF_W;
  localparam int PCNT_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;

  logic [1:0]        mode_q, bsz_q, dst_q;
  logic [3:0]        log_q;
  logic [7:0]        tmo_q;
  logic [8:0]        wptr_q;
  logic [11:0]       rptr_q, fill_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic              in_frame_q, req_q, lastw_q, irq_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [7:0]        units_q;
  logic [31:0]       rdata_q;

  logic [3:0]        log_eff;
  logic [11:0]       mask, wr_idx;
  logic [CNT_W-1:0]  cap;
  logic              room, run, acc, full_close, tmo_close, close;

  assign log_eff    = (log_q < 4'd5) ? 4'd5 : (log_q > 4'd12) ? 4'd12 : log_q;
  assign mask       = 12'((13'd1 << log_eff) - 13'd1);
  assign wr_idx     = {wptr_q, 3'b000};
  assign room       = ((rptr_q ^ wr_idx) & mask) != 12'd0;
  assign run        = (mode_q == 2'b10) || (mode_q == 2'b01 && in_frame_q);
  assign cap        = CNT_W'(UNIT_WORDS) * CNT_W'({1'b0, bsz_q} + 3'd1);
  assign full_close = req_q && mem_ack && lastw_q;
  assign tmo_close  = !req_q && (wcnt_q != '0) && (tmo_q != 8'd0) && (units_q >= tmo_q);
  assign close      = full_close || tmo_close;
  assign in_ready   = run && room && !req_q && !tmo_close;
  assign acc        = in_valid && in_ready;

  assign idle_o    = !run && !req_q;
  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;
  assign irq_o     = irq_q;
  assign fill_idx  = fill_q;
  assign reg_rdata = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[29:24], reg_wdata[19:18], reg_wdata[15:14], reg_wdata[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; bsz_q <= '0; dst_q <= '0; log_q <= '0; tmo_q <= '0;
      wptr_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) begin
        mode_q <= reg_wdata[31:30];
        log_q  <= reg_wdata[23:20];
        bsz_q  <= reg_wdata[17:16];
        dst_q  <= reg_wdata[13:12];
        tmo_q  <= reg_wdata[11:4];
      end else if (reg_addr == 2'd1) begin
        wptr_q <= reg_wdata[11:3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        2'd0:    rdata_q <= {mode_q, 6'b0, log_q, 2'b0, bsz_q, 2'b0, dst_q, tmo_q, 4'b0};
        2'd1:    rdata_q <= {20'b0, wptr_q, 3'b0};
        2'd2:    rdata_q <= {7'b0, idle_o, 12'b0, fill_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0; lastw_q <= 1'b0; addr_q <= '0; data_q <= '0;
      wcnt_q <= '0; in_frame_q <= 1'b0;
      rptr_q <= '0; fill_q <= 12'hFFF; irq_q <= 1'b0;
    end else begin
      irq_q <= close && (dst_q == 2'b01);
      if (acc) begin
        req_q      <= 1'b1;
        addr_q     <= {rptr_q & mask, wcnt_q[WOFF_W-1:0]};
        data_q     <= in_data;
        lastw_q    <= (wcnt_q + CNT_W'(1)) == cap;
        wcnt_q     <= wcnt_q + CNT_W'(1);
        in_frame_q <= !in_last;
      end else if (req_q && mem_ack) begin
        req_q <= 1'b0;
      end
      if (close) begin
        fill_q <= rptr_q & mask;
        rptr_q <= (rptr_q + 12'd1) & mask;
        wcnt_q <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0; units_q <= '0;
    end else if (acc || close) begin
      pcnt_q <= '0; units_q <= '0;
    end else if (pcnt_q == PCNT_W'(TICKS_PER_UNIT - 1)) begin
      pcnt_q <= '0;
      if (units_q != 8'hFF) units_q <= units_q + 8'd1;
    end else begin
      pcnt_q <= pcnt_q + PCNT_W'(1);
    end
  end

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  assert_no_take_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_fill_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill_q != $past(fill_q)) && ($past(dst_q) == 2'b01)) |-> irq_o);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!mem_req && !in_ready));

  assert_pause_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && mode_q == 2'b01 && !reg_wr) |=> !in_ready);
endmodule

// File: tb/rx_ring_ctrl_tb_top.sv
module rx_ring_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int UW = 4;
  localparam int TK = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [31:0] in_data = 0;
  logic mem_req, mem_ack = 0;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic irq_o, idle_o;
  logic [11:0] fill_idx;

  int n_chk = 0, n_bad = 0, irq_cnt = 0, wr_cnt = 0;
  logic [15:0] last_addr;
  logic [31:0] last_data, wdat = 32'h100;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_ctrl #(.DATA_W(32), .UNIT_WORDS(UW), .TICKS_PER_UNIT(TK)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack), .irq_o(irq_o), .fill_idx(fill_idx), .idle_o(idle_o));

  initial forever begin
    @(negedge clk);
    mem_ack = mem_req;
    if (mem_req) begin wr_cnt++; last_addr = mem_addr; last_data = mem_data; end
  end

  initial forever begin
    @(negedge clk);
    if (irq_o) irq_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic send_word(input logic last);
    in_valid = 1; in_data = wdat; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0; wdat++;
  endtask

  task automatic fill_buf(input int n);
    for (int b = 0; b < n; b++)
      for (int w = 0; w < UW; w++) send_word(w == UW-1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 idle", idle_o, 1); chk("R1 in_ready", in_ready, 0);
    chk("R1 irq", irq_o, 0); chk("R1 mem_req", mem_req, 0);
    chk("R1 fill_idx", fill_idx, 12'hFFF);
    reg_read(0, rd); chk("R1 config", rd, 0);
  endtask

  task automatic t_regs;
    reg_write(0, 32'hFFFF_FFFF); reg_read(0, rd); chk("R2 config mask", rd, 32'hC0F3_3FF0);
    chk("R7 mode 11 stopped", in_ready, 0);
    reg_write(1, 32'h0000_000D); reg_read(1, rd); chk("R2 write index", rd, 32'h8);
    reg_write(0, 0); reg_write(1, 0);
  endtask

  task automatic t_fill;
    reg_write(0, 32'h8050_1000); reg_write(1, 8);
    fill_buf(1);
    chk("R5 fill first", fill_idx, 0); chk("R6 irq count", irq_cnt, 1);
    chk("R9 write count", wr_cnt, 4); chk("R9 last addr", last_addr, 16'h0003);
    chk("R9 last data", last_data, wdat - 1);
  endtask

  task automatic t_full;
    fill_buf(7);
    chk("R5 fill seventh", fill_idx, 7); chk("R4 ring full", in_ready, 0);
    chk("R6 irq count", irq_cnt, 8);
  endtask

  task automatic t_wrap;
    reg_write(0, 32'h8020_1000); reg_write(1, 0);
    chk("R3 clamp room", in_ready, 1);
    fill_buf(24);
    chk("R3 fill top", fill_idx, 31); chk("R4 full at wrap", in_ready, 0);
    reg_write(1, 8); fill_buf(1);
    chk("R3 wrap to 0", fill_idx, 0); chk("R6 irq count", irq_cnt, 33);
  endtask

  task automatic t_noirq;
    reg_write(0, 32'h8050_0000); fill_buf(1);
    chk("R6 fill without irq", fill_idx, 1); chk("R6 no irq", irq_cnt, 33);
  endtask

  task automatic t_timeout;
    reg_write(0, 32'h8050_1020);
    send_word(0);
    repeat (5) @(negedge clk); chk("R10 not yet", fill_idx, 1);
    repeat (7) @(negedge clk); chk("R10 closed", fill_idx, 2);
    chk("R6 irq on timeout", irq_cnt, 34);
    send_word(0);
    repeat (5) @(negedge clk);
    send_word(0);
    repeat (5) @(negedge clk); chk("R10 restart", fill_idx, 2);
    repeat (7) @(negedge clk); chk("R10 closed after restart", fill_idx, 3);
    reg_write(0, 32'h8050_1000);
    send_word(0);
    repeat (40) @(negedge clk); chk("R10 zero disables", fill_idx, 3);
    reg_write(0, 32'h8050_1020);
    repeat (12) @(negedge clk); chk("R10 late enable", fill_idx, 4);
  endtask

  task automatic t_pause;
    reg_write(0, 32'h8050_1000);
    send_word(0); send_word(0);
    reg_write(0, 32'h4050_1000);
    @(negedge clk);
    chk("R8 frame open runs", in_ready, 1); chk("R8 not idle", idle_o, 0);
    send_word(1);
    repeat (2) @(negedge clk);
    chk("R8 stopped", in_ready, 0); chk("R8 idle", idle_o, 1);
    reg_read(2, rd); chk("R2 status idle", rd, 32'h0100_0004);
  endtask

  task automatic t_off;
    reg_write(0, 32'h8050_1000);
    send_word(0);
    reg_write(0, 0);
    chk("R7 stopped", in_ready, 0); chk("R7 idle", idle_o, 1);
    chk("R5 closed at off", fill_idx, 5);
    reg_read(2, rd); chk("R7 status", rd, 32'h0100_0005);
  endtask

  task automatic t_same_edge;
    reg_write(0, 32'h8050_1000);
    send_word(0); send_word(0); send_word(1);
    send_word(0);
    reg_write(1, 16);
    @(negedge clk);
    chk("R5 close with index write", fill_idx, 6); chk("R6 irq count", irq_cnt, 38);
    chk("R4 room after write", in_ready, 1);
    fill_buf(1);
    chk("R5 next fill", fill_idx, 7); chk("R4 write kept", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_regs; t_fill; t_full; t_wrap; t_noirq;
    t_timeout; t_pause; t_off; t_same_edge;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule